// File: doc/BRIEF.md
# Two-byte comma word aligner

This block sits behind a serial transceiver that hands over decoded 8b/10b data two bytes at a time, with one control-character flag per byte. The transceiver can settle one byte off, so the idle comma word (control byte 0xBC in the upper lane, data byte 0x50 in the lower lane) shows up as 0x50BC and stays that way. Left alone, every start-of-packet symbol is then split across two words and whole packets are lost.

The aligner watches the continuous idle traffic between packets. It looks for the comma in both byte orders, picks the matching lane arrangement and drives out realigned 16-bit words with their flags. Once it has seen enough commas in the chosen arrangement it raises a locked indication. The arrangement is frozen while locked, so a packet is never reshuffled halfway through. A run of commas in the other byte order first drops lock and then, if it continues, flips the arrangement.

Top module: `comma_aligner`

## Requirements
- R1: While rst_ni is low, data_o and k_o read zero and locked_o reads 0; the block leaves reset in straight (unswapped) mode.
- R2: In straight mode, data_o and k_o one cycle after an input word equal that word and its flags.
- R3: A straight-order comma is data_i = 0xBC50 with k_i = 2'b10 (bit 1 flags the upper byte as control, bit 0 flags the lower byte); the same bytes with any other flag pair are not a comma.
- R4: A swapped-order comma is a previous word whose lower byte is 0xBC with k bit 0 set, followed by a word whose upper byte is 0x50 with k bit 1 clear; 0x50BC with k_i = 2'b00 is not a comma.
- R5: While unlocked, locked_o rises after 4 back-to-back commas in the current mode's order; any other word restarts the count.
- R6: While unlocked, 4 back-to-back commas in the opposite order toggle the mode between straight and swapped, and all counts restart.
- R7: In swapped mode, data_o takes the previous input's lower byte as its upper byte and the current input's upper byte as its lower byte, one cycle later; k_o bits move the same way.
- R8: While locked, 4 back-to-back commas in the opposite order drop locked_o without changing the mode on that cycle.
- R9: The mode never changes while locked_o is high; fewer than 4 opposite commas leave lock and the lane arrangement untouched.
- R10: Starting locked in straight mode, a continuous 0x50BC / 2'b01 idle stream drops lock, flips to swapped mode, emits 0xBC50 with k_o = 2'b10, and regains lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 16 | Received word, upper byte first in time |
| k_i | input | 2 | Control flags, bit 1 for upper byte, bit 0 for lower byte |
| data_o | output | 16 | Realigned word |
| k_o | output | 2 | Realigned control flags |
| locked_o | output | 1 | Alignment locked |

## Verification
The two functions that meet in one cycle are the loss of lock and the mode flip, both driven by the same run of opposite-order commas. A locked link is fed a steady swapped idle stream, and the bench checks that the fourth opposite comma clears locked_o while the very next output word is still passed straight, and that only the eighth flips the lane arrangement. Random traffic that mixes both comma orders with arbitrary words then makes lock gain, lock loss and flips land on arbitrary cycles against a bench model of the lock rules.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [7:0]  COMMA_CTRL = 8'hBC;  // control byte of idle word
  localparam logic [7:0]  COMMA_DATA = 8'h50;  // data byte of idle word
  localparam int unsigned LOCK_RUN   = 4;
  localparam int unsigned SLIP_RUN   = 4;
endpackage

// File: rtl/aligner_comma_det.sv
module aligner_comma_det
  import aligner_pkg::*;
#(
  parameter int unsigned    BW    = BYTE_W,
  parameter logic [BW-1:0]  CTRL  = COMMA_CTRL[BW-1:0],
  parameter logic [BW-1:0]  DATA  = COMMA_DATA[BW-1:0],
  localparam int unsigned   WW    = 2 * BW
) (
  input  logic [WW-1:0] cur_data_i,
  input  logic [1:0]    cur_k_i,
  input  logic [WW-1:0] prev_data_i,
  input  logic [1:0]    prev_k_i,
  output logic          straight_hit_o,
  output logic          swap_hit_o
);
  logic [BW-1:0] cur_hi, cur_lo, prev_lo;

  assign cur_hi  = cur_data_i[WW-1 -: BW];
  assign cur_lo  = cur_data_i[BW-1:0];
  assign prev_lo = prev_data_i[BW-1:0];

  // comma fully inside the current word
  assign straight_hit_o = (cur_hi == CTRL) && (cur_lo == DATA) && (cur_k_i == 2'b10);

  // comma straddling previous lower lane and current upper lane
  assign swap_hit_o = (prev_lo == CTRL) && prev_k_i[0] &&
                      (cur_hi == DATA) && !cur_k_i[1];
endmodule

// File: rtl/aligner_lane_mux.sv
module aligner_lane_mux
  import aligner_pkg::*;
#(
  parameter int unsigned  BW = BYTE_W,
  localparam int unsigned WW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_i,
  input  logic [WW-1:0] data_i,
  input  logic [1:0]    k_i,
  output logic [WW-1:0] prev_data_o,
  output logic [1:0]    prev_k_o,
  output logic [WW-1:0] data_o,
  output logic [1:0]    k_o
);
  logic [WW-1:0] prev_d_q, out_d_q, out_d_n;
  logic [1:0]    prev_k_q, out_k_q, out_k_n;

  always_comb begin
    if (swap_i) begin
      out_d_n = {prev_d_q[BW-1:0], data_i[WW-1 -: BW]};
      out_k_n = {prev_k_q[0], k_i[1]};
    end else begin
      out_d_n = data_i;
      out_k_n = k_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_d_q <= '0;
      prev_k_q <= '0;
      out_d_q  <= '0;
      out_k_q  <= '0;
    end else begin
      prev_d_q <= data_i;
      prev_k_q <= k_i;
      out_d_q  <= out_d_n;
      out_k_q  <= out_k_n;
    end
  end

  assign prev_data_o = prev_d_q;
  assign prev_k_o    = prev_k_q;
  assign data_o      = out_d_q;
  assign k_o         = out_k_q;
endmodule

// File: rtl/aligner_lock_ctrl.sv
module aligner_lock_ctrl
  import aligner_pkg::*;
#(
  parameter int unsigned  GOOD_RUN = LOCK_RUN,
  parameter int unsigned  OPP_RUN  = SLIP_RUN,
  localparam int unsigned RUN_MAX  = (GOOD_RUN > OPP_RUN) ? GOOD_RUN : OPP_RUN,
  localparam int unsigned CNT_W    = $clog2(RUN_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic straight_hit_i,
  input  logic swap_hit_i,
  output logic swap_o,
  output logic locked_o
);
  localparam logic [CNT_W-1:0] GOOD_LAST = CNT_W'(GOOD_RUN - 1);
  localparam logic [CNT_W-1:0] OPP_LAST  = CNT_W'(OPP_RUN - 1);

  logic             swap_q, locked_q;
  logic [CNT_W-1:0] good_q, opp_q, good_n, opp_n;
  logic             good, opp, good_done, opp_done;

  assign good      = swap_q ? swap_hit_i : straight_hit_i;
  assign opp       = swap_q ? straight_hit_i : swap_hit_i;
  assign good_done = good && (good_q == GOOD_LAST);
  assign opp_done  = opp && (opp_q == OPP_LAST);

  // saturating run counters, cleared by any non-matching word
  always_comb begin
    good_n = '0;
    opp_n  = '0;
    if (good) good_n = (good_q == GOOD_LAST) ? good_q : good_q + 1'b1;
    if (opp)  opp_n  = (opp_q  == OPP_LAST)  ? opp_q  : opp_q  + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swap_q   <= 1'b0;
      locked_q <= 1'b0;
      good_q   <= '0;
      opp_q    <= '0;
    end else if (opp_done) begin
      good_q <= '0;
      opp_q  <= '0;
      if (locked_q) locked_q <= 1'b0;
      else          swap_q   <= ~swap_q;
    end else if (good_done && !locked_q) begin
      locked_q <= 1'b1;
      good_q   <= '0;
      opp_q    <= '0;
    end else begin
      good_q <= good_n;
      opp_q  <= opp_n;
    end
  end

  assign swap_o   = swap_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import aligner_pkg::*;
#(
  parameter int unsigned  BW       = BYTE_W,
  parameter int unsigned  GOOD_RUN = LOCK_RUN,
  parameter int unsigned  OPP_RUN  = SLIP_RUN,
  localparam int unsigned WW       = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] data_i,
  input  logic [1:0]    k_i,
  output logic [WW-1:0] data_o,
  output logic [1:0]    k_o,
  output logic          locked_o
);
  logic [WW-1:0] prev_data;
  logic [1:0]    prev_k;
  logic          straight_hit, swap_hit, swap_q;

  aligner_comma_det #(.BW(BW)) u_det (
    .cur_data_i     (data_i),
    .cur_k_i        (k_i),
    .prev_data_i    (prev_data),
    .prev_k_i       (prev_k),
    .straight_hit_o (straight_hit),
    .swap_hit_o     (swap_hit)
  );

  aligner_lock_ctrl #(.GOOD_RUN(GOOD_RUN), .OPP_RUN(OPP_RUN)) u_lock (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .straight_hit_i (straight_hit),
    .swap_hit_i     (swap_hit),
    .swap_o         (swap_q),
    .locked_o       (locked_o)
  );

  aligner_lane_mux #(.BW(BW)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swap_i      (swap_q),
    .data_i      (data_i),
    .k_i         (k_i),
    .prev_data_o (prev_data),
    .prev_k_o    (prev_k),
    .data_o      (data_o),
    .k_o         (k_o)
  );
endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
  parameter int unsigned  BW = 8,
  localparam int unsigned WW = 2 * BW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [WW-1:0] data_i,
  input logic [1:0]    k_i,
  input logic [WW-1:0] data_o,
  input logic [1:0]    k_o,
  input logic          locked_o,
  input logic          swap_q
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_state_chk: assert (!locked_o && data_o == '0 && k_o == '0);
  end

  // R2
  straight_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_q |=> (data_o == $past(data_i) && k_o == $past(k_i)));

  // R7
  swap_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_q |=> (data_o == {$past(data_i[BW-1:0], 2), $past(data_i[WW-1 -: BW])} &&
                k_o == {$past(k_i[0], 2), $past(k_i[1])}));

  // R9
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(swap_q));

  // R8
  drop_keeps_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $stable(swap_q));
endmodule

bind comma_aligner comma_aligner_chk #(.BW(BW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .k_i      (k_i),
  .data_o   (data_o),
  .k_o      (k_o),
  .locked_o (locked_o),
  .swap_q   (swap_q)
);

// File: tb/comma_aligner_tb.sv
module comma_aligner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN        = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic [1:0]  k_i = '0;
  logic [15:0] data_o;
  logic [1:0]  k_o;
  logic        locked_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  logic [15:0] m_prev_d, m_out_d;
  logic [1:0]  m_prev_k, m_out_k;
  bit          m_swap, m_lock;
  int          m_good, m_opp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  comma_aligner u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .k_i(k_i),
    .data_o(data_o), .k_o(k_o), .locked_o(locked_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_prev_d = '0; m_prev_k = '0; m_out_d = '0; m_out_k = '0;
    m_swap = 0; m_lock = 0; m_good = 0; m_opp = 0;
  endfunction

  // R3 / R4 comma definitions, R5/R6/R8 run rules
  function automatic void model_step(input logic [15:0] d, input logic [1:0] k);
    bit st, sw, good, opp;
    st = (d == 16'hBC50) && (k == 2'b10);
    sw = (m_prev_d[7:0] == 8'hBC) && m_prev_k[0] && (d[15:8] == 8'h50) && !k[1];
    good = m_swap ? sw : st;
    opp  = m_swap ? st : sw;
    if (m_swap) begin
      m_out_d = {m_prev_d[7:0], d[15:8]};
      m_out_k = {m_prev_k[0], k[1]};
    end else begin
      m_out_d = d;
      m_out_k = k;
    end
    if (opp && m_opp == RUN-1) begin
      m_good = 0; m_opp = 0;
      if (m_lock) m_lock = 0; else m_swap = !m_swap;
    end else if (good && m_good == RUN-1 && !m_lock) begin
      m_lock = 1; m_good = 0; m_opp = 0;
    end else begin
      m_good = good ? ((m_good == RUN-1) ? m_good : m_good + 1) : 0;
      m_opp  = opp  ? ((m_opp  == RUN-1) ? m_opp  : m_opp  + 1) : 0;
    end
    m_prev_d = d;
    m_prev_k = k;
  endfunction

  task automatic step(input logic [15:0] d, input logic [1:0] k);
    string tag;
    bit    was_swap;
    data_i = d;
    k_i    = k;
    was_swap = m_swap;
    @(posedge clk_i);
    model_step(d, k);
    @(negedge clk_i);
    tag = was_swap ? "R7 data" : "R2 data";
    chk({k_o, data_o} == {m_out_k, m_out_d}, tag, {14'd0, k_o, data_o}, {14'd0, m_out_k, m_out_d});
    chk(locked_o == m_lock, "R5 locked", 32'(locked_o), 32'(m_lock));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    data_i = '0;
    k_i = '0;
    model_reset();
    repeat (2) @(negedge clk_i);
    chk(!locked_o && data_o == '0 && k_o == '0, "R1 reset", {13'd0, locked_o, k_o, data_o}, 32'd0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20817));
    model_reset();
    do_reset();

    // R2: random straight traffic
    for (int i = 0; i < 200; i++) step(16'($urandom), 2'($urandom));

    // R3: comma bytes with wrong flags never lock
    do_reset();
    for (int i = 0; i < 8; i++) step(16'hBC50, 2'b11);
    for (int i = 0; i < 8; i++) step(16'hBC50, 2'b00);
    chk(locked_o == 1'b0, "R3 bad flags", 32'(locked_o), 32'd0);

    // R4: swapped bytes without flags never flip
    for (int i = 0; i < 10; i++) step(16'h50BC, 2'b00);
    chk(data_o == 16'h50BC, "R4 no flip", 32'(data_o), 32'h50BC);

    // R5: broken run restarts count
    for (int i = 0; i < 3; i++) step(16'hBC50, 2'b10);
    chk(locked_o == 1'b0, "R5 three", 32'(locked_o), 32'd0);
    step(16'hAAAA, 2'b00);
    for (int i = 0; i < 3; i++) step(16'hBC50, 2'b10);
    chk(locked_o == 1'b0, "R5 restart", 32'(locked_o), 32'd0);
    step(16'hBC50, 2'b10);
    chk(locked_o == 1'b1, "R5 lock", 32'(locked_o), 32'd1);

    // R9: three opposite commas while locked change nothing
    for (int i = 0; i < 4; i++) step(16'h50BC, 2'b01);
    chk(locked_o == 1'b1, "R9 lock kept", 32'(locked_o), 32'd1);
    chk(data_o == 16'h50BC, "R9 no swap", 32'(data_o), 32'h50BC);
    step(16'hBC50, 2'b10);

    // R8 / R6 / R10: continuous swapped idle while locked
    for (int i = 1; i <= 13; i++) begin
      step(16'h50BC, 2'b01);
      if (i == 4)  chk(locked_o == 1'b1, "R8 before", 32'(locked_o), 32'd1);
      if (i == 5)  chk(locked_o == 1'b0, "R8 drop", 32'(locked_o), 32'd0);
      if (i == 6)  chk(data_o == 16'h50BC, "R8 mode kept", 32'(data_o), 32'h50BC);
      if (i == 9)  chk(data_o == 16'h50BC, "R6 pre flip", 32'(data_o), 32'h50BC);
      if (i == 10) chk({k_o, data_o} == {2'b10, 16'hBC50}, "R7 realigned", {14'd0, k_o, data_o}, {14'd0, 2'b10, 16'hBC50});
      if (i == 12) chk(locked_o == 1'b0, "R10 not yet", 32'(locked_o), 32'd0);
      if (i == 13) chk(locked_o == 1'b1, "R10 relock", 32'(locked_o), 32'd1);
    end

    // R7: random data in swapped mode
    for (int i = 0; i < 200; i++) step(16'($urandom), 2'($urandom));

    // R6/R8 mix: random words and commas of both orders
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 4)      step(16'hBC50, 2'b10);
      else if (sel < 8) step(16'h50BC, 2'b01);
      else              step(16'($urandom), 2'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule